// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block owns a bank of sixteen message mailboxes, each holding an identifier, a format bit and a transmit-request flag. When the host triggers a search, a scan engine visits the mailboxes one per clock, from box 0 up to a programmable last index. It keeps the pending box with the numerically smallest comparison key. At the end of the scan it latches the winning index and flags whether any box competed.

Standard (11-bit) and extended (29-bit) identifiers are ranked together. A standard identifier is placed in the top eleven key bits, and the key bits below it are zero. When the controller reports that the winning frame went out, the block clears that mailbox's request. The host can then search again for the next frame. The last-index register accepts writes only while the controller is in its initialization state.

Top module: `tx_prio_arbiter`

## Requirements
- R1: After reset, all request flags are 0, `valid_o`, `done_o` and `busy_o` are 0, `win_idx_o` is 0, and `last_idx_o` is 15.
- R2: A write to the last index through `last_wr_i` takes effect on the next edge only when `init_mode_i` is 1. When `init_mode_i` is 0 the write is ignored and `last_idx_o` keeps its value.
- R3: A trigger on `search_i` that is sampled while idle sets `busy_o` on that edge. `done_o` is high for exactly the one cycle that follows the edge `last+1` cycles after the trigger edge. `busy_o` falls on that same edge. A trigger sampled while `busy_o` is 1 is ignored.
- R4: Only boxes with an index from 0 to the last index and a request flag of 1 take part. If no such box exists, `valid_o` is 0 after `done_o`.
- R5: The winner has the smallest key. The key is the 29-bit identifier when the box's format bit is 1 (extended). It is `{id[10:0], 18'b0}` when the format bit is 0 (standard). `win_idx_o` gives its index and `valid_o` is 1.
- R6: When two keys are equal, the lower mailbox index wins.
- R7: A pulse on `tx_ok_i` while `valid_o` is 1 clears the winner's request flag and `valid_o` on that edge. A pulse while `valid_o` is 0 changes no request flag.
- R8: `box_wr_i` stores `box_ext_i` and `box_id_i` into box `box_sel_i`. `req_set_i` sets that box's request flag. `req_o[b]` shows the flag of box b.
- R9: `win_idx_o` changes only when `done_o` rises and holds its value through `tx_ok_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_mode_i | input | 1 | Controller in initialization state |
| last_wr_i | input | 1 | Write strobe for the last index |
| last_idx_i | input | 4 | Last mailbox index to search |
| last_idx_o | output | 4 | Current last index |
| box_wr_i | input | 1 | Write identifier and format of the selected box |
| req_set_i | input | 1 | Set the request flag of the selected box |
| box_sel_i | input | 4 | Selected mailbox |
| box_ext_i | input | 1 | Format bit: 1 extended, 0 standard |
| box_id_i | input | 29 | Identifier; a standard identifier sits in bits 10:0 |
| req_o | output | 16 | Request flags, bit b for box b |
| search_i | input | 1 | Search trigger |
| busy_o | output | 1 | Search trigger bit, self-clearing |
| done_o | output | 1 | One-cycle end-of-search pulse |
| valid_o | output | 1 | A winner was found |
| win_idx_o | output | 4 | Index of the winning mailbox |
| tx_ok_i | input | 1 | Winning frame sent successfully |

## Verification
Inputs are driven and outputs are read at the falling edge. Each read therefore shows the registers updated by the rising edge just passed.

After a trigger edge, the bench reads `done_o` once per cycle. It expects `done_o` to be 0 after edges 1 to `last` and 1 only after edge `last+1`, and it checks the winner at that read. One cycle later it expects both `done_o` and `busy_o` to be back to 0.

Writes to the last index, request sets and `tx_ok_i` pulses each take effect one edge after they are driven. The bench reads their results at the very next falling edge.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef logic [ID_W-1:0] key_t;

  // standard id occupies the key MSBs, zeros below
  function automatic key_t make_key(input logic ext, input logic [ID_W-1:0] id);
    return ext ? id : {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
  endfunction
endpackage

// File: rtl/tx_arb_bank.sv
module tx_arb_bank
  import tx_arb_pkg::*;
#(
  parameter int N_BOX = 16,
  localparam int IX_W = $clog2(N_BOX)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       set_i,
  input  logic [IX_W-1:0]            sel_i,
  input  logic                       ext_i,
  input  logic [ID_W-1:0]            id_i,
  input  logic                       clr_i,
  input  logic [IX_W-1:0]            clr_idx_i,
  output logic [N_BOX-1:0]           req_o,
  output logic [N_BOX-1:0][ID_W-1:0] key_o
);
  for (genvar b = 0; b < N_BOX; b++) begin : g_box
    logic            ext_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ext_q <= 1'b0;
        id_q  <= '0;
      end else if (wr_i && sel_i == IX_W'(b)) begin
        ext_q <= ext_i;
        id_q  <= id_i;
      end
    end

    // a fresh host request wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              req_o[b] <= 1'b0;
      else if (set_i && sel_i == IX_W'(b))      req_o[b] <= 1'b1;
      else if (clr_i && clr_idx_i == IX_W'(b))  req_o[b] <= 1'b0;
    end

    assign key_o[b] = make_key(ext_q, id_q);
  end
endmodule

// File: rtl/tx_arb_scan.sv
module tx_arb_scan
  import tx_arb_pkg::*;
#(
  parameter int N_BOX = 16,
  localparam int IX_W = $clog2(N_BOX)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [IX_W-1:0]            last_i,
  input  logic [N_BOX-1:0]           req_i,
  input  logic [N_BOX-1:0][ID_W-1:0] keys_i,
  input  logic                       ack_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       valid_o,
  output logic [IX_W-1:0]            win_o
);
  logic [IX_W-1:0] ptr_q, last_q, best_idx_q;
  key_t            best_key_q;
  logic            found_q;
  logic            take;
  logic            found_nx;
  logic [IX_W-1:0] idx_nx;

  // strict compare: the earlier (lower) index keeps a tie
  assign take     = req_i[ptr_q] && (!found_q || (keys_i[ptr_q] < best_key_q));
  assign found_nx = found_q | take;
  assign idx_nx   = take ? ptr_q : best_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      valid_o    <= 1'b0;
      win_o      <= '0;
      ptr_q      <= '0;
      last_q     <= '0;
      best_idx_q <= '0;
      best_key_q <= '0;
      found_q    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o  <= 1'b1;
          ptr_q   <= '0;
          last_q  <= last_i;
          found_q <= 1'b0;
          valid_o <= 1'b0;
        end else if (ack_i && valid_o) begin
          valid_o <= 1'b0;
        end
      end else begin
        if (take) begin
          found_q    <= 1'b1;
          best_idx_q <= ptr_q;
          best_key_q <= keys_i[ptr_q];
        end
        if (ptr_q == last_q) begin
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          valid_o <= found_nx;
          win_o   <= idx_nx;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_BUSY_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R3
  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ptr_q <= last_q)); // R4
  AST_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(win_o)); // R9
endmodule

// File: rtl/tx_prio_arbiter.sv
module tx_prio_arbiter
  import tx_arb_pkg::*;
#(
  parameter int N_BOX = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       init_mode_i,
  input  logic                       last_wr_i,
  input  logic [$clog2(N_BOX)-1:0]   last_idx_i,
  output logic [$clog2(N_BOX)-1:0]   last_idx_o,
  input  logic                       box_wr_i,
  input  logic                       req_set_i,
  input  logic [$clog2(N_BOX)-1:0]   box_sel_i,
  input  logic                       box_ext_i,
  input  logic [ID_W-1:0]            box_id_i,
  output logic [N_BOX-1:0]           req_o,
  input  logic                       search_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       valid_o,
  output logic [$clog2(N_BOX)-1:0]   win_idx_o,
  input  logic                       tx_ok_i
);
  localparam int IX_W = $clog2(N_BOX);

  logic [N_BOX-1:0][ID_W-1:0] keys;
  logic                       clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        last_idx_o <= IX_W'(N_BOX - 1);
    else if (last_wr_i && init_mode_i)  last_idx_o <= last_idx_i;
  end

  assign clr = tx_ok_i && valid_o;

  tx_arb_bank #(.N_BOX(N_BOX)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (box_wr_i),
    .set_i     (req_set_i),
    .sel_i     (box_sel_i),
    .ext_i     (box_ext_i),
    .id_i      (box_id_i),
    .clr_i     (clr),
    .clr_idx_i (win_idx_o),
    .req_o     (req_o),
    .key_o     (keys)
  );

  tx_arb_scan #(.N_BOX(N_BOX)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (search_i),
    .last_i  (last_idx_o),
    .req_i   (req_o),
    .keys_i  (keys),
    .ack_i   (tx_ok_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .valid_o (valid_o),
    .win_o   (win_idx_o)
  );

  AST_LAST_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_mode_i |=> $stable(last_idx_o)); // R2
  AST_WIN_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> req_o[win_idx_o]); // R5
  AST_CLEAR_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ok_i && valid_o && !(req_set_i && box_sel_i == win_idx_o))
      |=> (!req_o[$past(win_idx_o)] && !valid_o)); // R7
endmodule

// File: tb/tb_tx_prio_arbiter.sv
`timescale 1ns/1ps
module tb_tx_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_mode = 1'b0, last_wr = 1'b0, box_wr = 1'b0, req_set = 1'b0;
  logic [3:0]  last_idx_in = '0, box_sel = '0;
  logic        box_ext = 1'b0;
  logic [28:0] box_id = '0;
  logic        search = 1'b0, tx_ok = 1'b0;
  logic [3:0]  last_idx_out, win_idx;
  logic [15:0] req;
  logic        busy, done, valid;

  int total = 0, bad = 0;
  bit over = 0;

  logic [28:0] m_key [16];
  bit          m_req [16];

  always #4 clk = ~clk;

  tx_prio_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .init_mode_i(init_mode), .last_wr_i(last_wr),
    .last_idx_i(last_idx_in), .last_idx_o(last_idx_out), .box_wr_i(box_wr),
    .req_set_i(req_set), .box_sel_i(box_sel), .box_ext_i(box_ext), .box_id_i(box_id),
    .req_o(req), .search_i(search), .busy_o(busy), .done_o(done), .valid_o(valid),
    .win_idx_o(win_idx), .tx_ok_i(tx_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [28:0] key_of(input bit ext, input logic [28:0] id);
    return ext ? id : (29'(id[10:0]) << 18);
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic put_box(input int b, input bit ext, input logic [28:0] id);
    box_sel = 4'(b); box_ext = ext; box_id = id; box_wr = 1'b1;
    cyc(); box_wr = 1'b0;
    m_key[b] = key_of(ext, id);
  endtask

  task automatic set_req(input int b);
    box_sel = 4'(b); req_set = 1'b1;
    cyc(); req_set = 1'b0;
    m_req[b] = 1;
  endtask

  task automatic set_last(input int l);
    init_mode = 1'b1; last_wr = 1'b1; last_idx_in = 4'(l);
    cyc(); last_wr = 1'b0; init_mode = 1'b0;
  endtask

  // returns expected winner, -1 if none
  function automatic int model_win(input int l);
    int best = -1;
    for (int i = 0; i <= l; i++)
      if (m_req[i] && (best < 0 || m_key[i] < m_key[best])) best = i;
    return best;
  endfunction

  task automatic search_chk(input int l, input bit retrig, output int got);
    int exp_w = model_win(l);
    bit tim_ok = 1;
    search = 1'b1;
    cyc(); search = 1'b0;
    chk(busy === 1'b1, "R3 busy after trigger", busy, 1);
    for (int k = 1; k <= l + 1; k++) begin
      if (retrig && k == 1) search = 1'b1;
      cyc();
      search = 1'b0;
      if (done !== (k == l + 1)) tim_ok = 0;
    end
    chk(tim_ok, "R3 done timing", l, l);
    if (exp_w < 0) chk(valid === 1'b0, "R4 no pending box", valid, 0);
    else begin
      chk(valid === 1'b1, "R5 valid", valid, 1);
      chk(int'(win_idx) == exp_w, "R5 R6 winner", win_idx, exp_w);
    end
    got = exp_w;
    cyc();
    chk(done === 1'b0 && busy === 1'b0, "R3 done pulse ends",
        {30'b0, done, busy}, 0);
  endtask

  task automatic send_ok(input int w);
    tx_ok = 1'b1;
    cyc(); tx_ok = 1'b0;
    chk(req[w] === 1'b0 && valid === 1'b0, "R7 clear on tx_ok",
        {30'b0, req[w], valid}, 0);
    chk(int'(win_idx) == w, "R9 index held", win_idx, w);
    m_req[w] = 0;
  endtask

  task automatic drain();
    int w;
    set_last(15);
    do begin
      search_chk(15, 0, w);
      if (w >= 0) send_ok(w);
    end while (w >= 0);
  endtask

  initial begin
    int w;
    for (int i = 0; i < 16; i++) begin m_key[i] = '0; m_req[i] = 0; end
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(req === 16'h0 && valid === 1'b0 && done === 1'b0 && busy === 1'b0,
        "R1 reset flags", {req, valid, done, busy}, 0);
    chk(win_idx === 4'd0 && last_idx_out === 4'd15, "R1 reset indices",
        {win_idx, last_idx_out}, 15);

    // R2: write outside init ignored
    last_wr = 1'b1; last_idx_in = 4'd3; init_mode = 1'b0;
    cyc(); last_wr = 1'b0;
    chk(last_idx_out === 4'd15, "R2 write ignored", last_idx_out, 15);
    set_last(5);
    chk(last_idx_out === 4'd5, "R2 write in init", last_idx_out, 5);

    search_chk(5, 0, w);

    // R8 R6 R5 directed: equal keys std/ext, then a smaller extended key
    put_box(4, 0, 29'h0A0);
    put_box(1, 1, 29'h0A0 << 18);
    set_req(4);
    chk(req === 16'h0010, "R8 request set", req, 16'h0010);
    set_req(1);
    set_last(15);
    search_chk(15, 0, w);
    chk(w == 1, "R6 tie lower index", w, 1);
    put_box(6, 1, (29'h0A0 << 18) - 29'd1);
    set_req(6);
    search_chk(15, 1, w);
    chk(w == 6, "R5 smaller extended", w, 6);
    send_ok(6);
    drain();

    // R7: tx_ok with valid low leaves requests alone
    set_req(2);
    tx_ok = 1'b1; cyc(); tx_ok = 1'b0;
    chk(req[2] === 1'b1, "R7 tx_ok ignored", req[2], 1);
    drain();

    // sweep of last index with random tie-heavy contents
    for (int t = 0; t < 48; t++) begin
      int l = t % 16;
      for (int b = 0; b < 16; b++) begin
        bit ext = 1'($urandom % 2);
        logic [28:0] top = 29'($urandom % 4);
        logic [28:0] lo  = ($urandom % 2) ? 29'd0 : 29'($urandom % 8);
        put_box(b, ext, ext ? ((top << 18) | lo) : top);
        if ($urandom % 3 != 0) set_req(b);
      end
      chk(req == {m_req[15], m_req[14], m_req[13], m_req[12], m_req[11], m_req[10],
                  m_req[9], m_req[8], m_req[7], m_req[6], m_req[5], m_req[4],
                  m_req[3], m_req[2], m_req[1], m_req[0]}, "R8 request image", req, 0);
      set_last(l);
      search_chk(l, (t % 5) == 0, w);
      drain();
    end

    over = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!over) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule